// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Back Data Cache

This block sits between a processor load/store port and a slower backing memory. Each processor request carries a word address, a read/write flag and write data. The address splits into a word offset, a set index and a tag. The set index picks one set of two ways. Both stored tags of that set are compared with the request tag in the same cycle. On a hit the block answers in the cycle of the request and does not touch memory.

On a miss a small sequencer takes over. It picks a victim way, and an empty way is always taken before the least recently used one. If the victim holds modified data, the whole line is first written back to memory. The missing line is then fetched, and the request is served once the sequencer returns to lookup. Writes stay in the cache and mark their line dirty. A write miss allocates the line first and then merges the word into it. Memory traffic is always whole lines, moved with a request/acknowledge handshake.

Top module: `cache2w_top`

## Requirements
- R1: The address is decoded as follows. The word offset is the low WORD_W bits (2 by default). The set index is the next SET_W bits (4 by default, bits 5:2). The tag is the remaining upper TAG_W bits (18 by default, bits 23:6). Block addresses on the memory port are {tag, set}. Word i of a line occupies line bits [i*DATA_W +: DATA_W].
- R2: A request whose block is valid in either way of its set is a hit. The block raises cpu_ready in the same cycle with the addressed word on cpu_rdata, and raises no memory request.
- R3: Two blocks with the same set index but different tags can be resident in one set at the same time.
- R4: A miss whose victim is clean or empty issues exactly one fill (mem_req=1, mem_we=0, mem_addr={tag,set}). The request completes as a hit in the cycle after the fill is acknowledged.
- R5: An empty way is filled before any valid way is evicted. Otherwise the victim is the way of the set that was not the most recent to hit or be filled.
- R6: A write hit updates only the cache: no memory request is made, and later reads of that address return the new word.
- R7: A dirty victim is written back as a whole line (mem_we=1, mem_addr={victim tag,set}) before the fill. A clean victim is never written back.
- R8: A write miss fetches the line first and then merges the write data into the addressed word. The other words keep their memory values, and the line becomes dirty.
- R9: Once mem_req is raised, mem_req, mem_we and mem_addr stay unchanged until mem_ack is seen.
- R10: After reset cpu_ready and mem_req are low, and every way is empty, so the first access to any set misses.
- R11: cpu_ready stays low for the whole miss sequence (write-back and fill), and never coincides with mem_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_req | input | 1 | Processor request valid |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W (24) | Word address {tag, set, word} |
| cpu_wdata | input | DATA_W (16) | Write data |
| cpu_rdata | output | DATA_W (16) | Read data, valid while cpu_ready |
| cpu_ready | output | 1 | Request completes this cycle |
| mem_req | output | 1 | Memory line transfer request |
| mem_we | output | 1 | 1 = write-back, 0 = fill |
| mem_addr | output | BLK_W (22) | Block address {tag, set} |
| mem_wdata | output | LINE_W (64) | Line written back |
| mem_rdata | input | LINE_W (64) | Line returned by a fill, valid with mem_ack |
| mem_ack | input | 1 | One-cycle acknowledge of the current transfer |

## Verification
The properties rely on two things from the outside. First, the processor holds cpu_req, cpu_we, cpu_addr and cpu_wdata unchanged from the cycle it raises a request until cpu_ready. Second, memory gives one single-cycle mem_ack per transfer, only while mem_req is high. The property that a completed fill yields a hit in the next cycle depends on the first of these. The bench drives each request at a falling edge and holds it until it sees ready. Its memory model counts a fixed latency from the request and pulses the acknowledge exactly once per transfer. It also reports any change of address or direction seen during an open transfer.

// File: rtl/cache2w_pkg.sv
package cache2w_pkg;

  typedef enum logic [1:0] {
    ST_LOOKUP = 2'd0,
    ST_WBACK  = 2'd1,
    ST_REFILL = 2'd2
  } cstate_e;

  // Empty ways first, then the way the LRU bit points at.
  function automatic logic pick_victim(input logic [1:0] vld, input logic lru);
    if (!vld[0]) return 1'b0;
    if (!vld[1]) return 1'b1;
    return lru;
  endfunction

endpackage

// File: rtl/cache2w_tags.sv
module cache2w_tags #(
  parameter int TAG_W = 18,
  parameter int SET_W = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [SET_W-1:0]       set_idx,
  input  logic [TAG_W-1:0]       look_tag,
  output logic [1:0]             way_hit,
  output logic [1:0]             way_vld,
  output logic [1:0]             way_dty,
  output logic [1:0][TAG_W-1:0]  way_tag,
  output logic                   lru_bit,
  input  logic                   touch_en,
  input  logic                   touch_way,
  input  logic                   mark_dirty,
  input  logic                   fill_en,
  input  logic                   fill_way,
  input  logic [TAG_W-1:0]       fill_tag
);
  localparam int SETS = 1 << SET_W;

  logic [SETS-1:0] lru_q;

  for (genvar w = 0; w < 2; w++) begin : g_way
    logic [TAG_W-1:0] tag_q [SETS];
    logic [SETS-1:0]  vld_q;
    logic [SETS-1:0]  dty_q;
    logic             fill_me;
    logic             touch_me;

    assign fill_me  = fill_en  && (fill_way  == 1'(w));
    assign touch_me = touch_en && (touch_way == 1'(w));

    always_ff @(posedge clk) begin
      if (fill_me) tag_q[set_idx] <= fill_tag;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q <= '0;
        dty_q <= '0;
      end else if (fill_me) begin
        vld_q[set_idx] <= 1'b1;
        dty_q[set_idx] <= 1'b0;
      end else if (touch_me && mark_dirty) begin
        dty_q[set_idx] <= 1'b1;
      end
    end

    assign way_vld[w] = vld_q[set_idx];
    assign way_dty[w] = dty_q[set_idx];
    assign way_tag[w] = tag_q[set_idx];
    assign way_hit[w] = vld_q[set_idx] && (tag_q[set_idx] == look_tag);
  end

  // LRU bit names the way to evict next: the other one from the last use.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        lru_q <= '0;
    else if (fill_en)  lru_q[set_idx] <= ~fill_way;
    else if (touch_en) lru_q[set_idx] <= ~touch_way;
  end

  assign lru_bit = lru_q[set_idx];

endmodule

// File: rtl/cache2w_lines.sv
module cache2w_lines #(
  parameter int SET_W  = 4,
  parameter int LINE_W = 64
) (
  input  logic                   clk,
  input  logic [SET_W-1:0]       set_idx,
  input  logic                   wr_en,
  input  logic                   wr_way,
  input  logic [LINE_W-1:0]      wr_line,
  output logic [1:0][LINE_W-1:0] rd_lines
);
  localparam int SETS = 1 << SET_W;

  for (genvar w = 0; w < 2; w++) begin : g_way
    logic [LINE_W-1:0] line_q [SETS];

    always_ff @(posedge clk) begin
      if (wr_en && (wr_way == 1'(w))) line_q[set_idx] <= wr_line;
    end

    assign rd_lines[w] = line_q[set_idx];
  end

endmodule

// File: rtl/cache2w_fsm.sv
module cache2w_fsm
  import cache2w_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    miss,
  input  logic    victim_dirty,
  input  logic    mem_ack,
  output cstate_e state,
  output logic    fill_done
);
  cstate_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_LOOKUP: if (miss)    nxt = victim_dirty ? ST_WBACK : ST_REFILL;
      ST_WBACK:  if (mem_ack) nxt = ST_REFILL;
      ST_REFILL: if (mem_ack) nxt = ST_LOOKUP;
      default:                nxt = ST_LOOKUP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_LOOKUP;
    else        state <= nxt;
  end

  assign fill_done = (state == ST_REFILL) && mem_ack;

endmodule

// File: rtl/cache2w_top.sv
module cache2w_top
  import cache2w_pkg::*;
#(
  parameter int TAG_W  = 18,
  parameter int SET_W  = 4,
  parameter int WORD_W = 2,
  parameter int DATA_W = 16,
  localparam int ADDR_W = TAG_W + SET_W + WORD_W,
  localparam int BLK_W  = TAG_W + SET_W,
  localparam int LINE_W = DATA_W << WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_ready,
  output logic              mem_req,
  output logic              mem_we,
  output logic [BLK_W-1:0]  mem_addr,
  output logic [LINE_W-1:0] mem_wdata,
  input  logic [LINE_W-1:0] mem_rdata,
  input  logic              mem_ack
);

  function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction

  function automatic logic [SET_W-1:0] set_of(input logic [ADDR_W-1:0] a);
    return a[WORD_W +: SET_W];
  endfunction

  function automatic logic [DATA_W-1:0] word_of(input logic [LINE_W-1:0] line,
                                                 input logic [WORD_W-1:0] idx);
    return line[idx*DATA_W +: DATA_W];
  endfunction

  function automatic logic [LINE_W-1:0] merge_word(input logic [LINE_W-1:0] line,
                                                    input logic [WORD_W-1:0] idx,
                                                    input logic [DATA_W-1:0] wd);
    logic [LINE_W-1:0] r;
    r = line;
    r[idx*DATA_W +: DATA_W] = wd;
    return r;
  endfunction

  logic [TAG_W-1:0]            req_tag;
  logic [SET_W-1:0]            req_set;
  logic [WORD_W-1:0]           req_word;
  logic [1:0]                  way_hit, way_vld, way_dty;
  logic [1:0][TAG_W-1:0]       way_tag;
  logic [1:0][LINE_W-1:0]      rd_lines;
  logic                        lru_bit, hit_any, hit_way, victim, vic_dirty;
  logic                        in_lookup, ev_hit, ev_miss, fill_done;
  logic                        wr_en, wr_way;
  logic [LINE_W-1:0]           hit_line, wr_line;
  cstate_e                     state;

  assign req_tag  = tag_of(cpu_addr);
  assign req_set  = set_of(cpu_addr);
  assign req_word = cpu_addr[WORD_W-1:0];

  cache2w_tags #(.TAG_W(TAG_W), .SET_W(SET_W)) u_tags (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_idx    (req_set),
    .look_tag   (req_tag),
    .way_hit    (way_hit),
    .way_vld    (way_vld),
    .way_dty    (way_dty),
    .way_tag    (way_tag),
    .lru_bit    (lru_bit),
    .touch_en   (ev_hit),
    .touch_way  (hit_way),
    .mark_dirty (cpu_we),
    .fill_en    (fill_done),
    .fill_way   (victim),
    .fill_tag   (req_tag)
  );

  cache2w_lines #(.SET_W(SET_W), .LINE_W(LINE_W)) u_lines (
    .clk      (clk),
    .set_idx  (req_set),
    .wr_en    (wr_en),
    .wr_way   (wr_way),
    .wr_line  (wr_line),
    .rd_lines (rd_lines)
  );

  cache2w_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .miss         (ev_miss),
    .victim_dirty (vic_dirty),
    .mem_ack      (mem_ack),
    .state        (state),
    .fill_done    (fill_done)
  );

  // Named events used by the checker.
  assign hit_any   = |way_hit;
  assign hit_way   = way_hit[1];
  assign in_lookup = (state == ST_LOOKUP);
  assign ev_hit    = in_lookup && cpu_req && hit_any;
  assign ev_miss   = in_lookup && cpu_req && !hit_any;
  assign victim    = pick_victim(way_vld, lru_bit);
  assign vic_dirty = way_vld[victim] && way_dty[victim];

  assign hit_line  = rd_lines[hit_way];
  assign cpu_ready = ev_hit;
  assign cpu_rdata = word_of(hit_line, req_word);

  assign wr_en   = fill_done || (ev_hit && cpu_we);
  assign wr_way  = fill_done ? victim : hit_way;
  assign wr_line = fill_done ? mem_rdata : merge_word(hit_line, req_word, cpu_wdata);

  assign mem_req   = !in_lookup;
  assign mem_we    = (state == ST_WBACK);
  assign mem_addr  = mem_we ? {way_tag[victim], req_set} : {req_tag, req_set};
  assign mem_wdata = rd_lines[victim];

endmodule

// File: rtl/cache2w_chk.sv
module cache2w_chk #(
  parameter int BLK_W = 22
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cpu_req,
  input logic             cpu_ready,
  input logic             mem_req,
  input logic             mem_we,
  input logic             mem_ack,
  input logic [BLK_W-1:0] mem_addr,
  input logic [1:0]       way_hit,
  input logic             vic_dirty
);
  // R3
  single_way_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req |-> $onehot0(way_hit));

  // R9
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R7
  wb_only_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> vic_dirty);

  // R4
  fill_then_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we && mem_ack) |=> cpu_ready);

  // R11
  hit_no_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |=> !mem_req);

endmodule

bind cache2w_top cache2w_chk #(.BLK_W(BLK_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cpu_req   (cpu_req),
  .cpu_ready (cpu_ready),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_ack   (mem_ack),
  .mem_addr  (mem_addr),
  .way_hit   (way_hit),
  .vic_dirty (vic_dirty)
);

// File: tb/tb_cache2w_top.sv
`timescale 1ns/1ps
module tb_cache2w_top;
  localparam int LAT = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [23:0] cpu_addr = '0;
  logic [15:0] cpu_wdata = '0, cpu_rdata;
  logic        cpu_ready, mem_req, mem_we;
  logic [21:0] mem_addr;
  logic [63:0] mem_wdata;
  logic [63:0] mem_rdata = '0;
  logic        mem_ack = 1'b0;

  always #4 clk = ~clk;

  cache2w_top dut (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .cpu_ready(cpu_ready), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ack(mem_ack)
  );

  int checks = 0, errors = 0;
  int fills = 0, wbs = 0, hs_bad = 0, overlap = 0;
  logic [21:0] last_fill, last_wb;
  logic [63:0] last_wb_line;

  // backing store: pattern unless a line was written back
  logic [21:0] wb_a [64];
  logic [63:0] wb_l [64];
  int          wb_n = 0;
  // reference model of processor-visible words
  logic [23:0] gw_a [64];
  logic [15:0] gw_d [64];
  int          gw_n = 0;

  function automatic logic [15:0] pat(input logic [21:0] blk, input logic [1:0] i);
    return {blk[13:0], i};
  endfunction

  function automatic logic [63:0] line_of(input logic [21:0] blk);
    logic [63:0] l;
    for (int i = 0; i < 4; i++) l[i*16 +: 16] = pat(blk, 2'(i));
    for (int k = 0; k < wb_n; k++) if (wb_a[k] == blk) l = wb_l[k];
    return l;
  endfunction

  function automatic logic [15:0] golden(input logic [23:0] a);
    logic [15:0] d;
    d = pat(a[23:2], a[1:0]);
    for (int k = 0; k < gw_n; k++) if (gw_a[k] == a) d = gw_d[k];
    return d;
  endfunction

  function automatic logic [23:0] mk(input int t, input int s, input int w);
    return {t[17:0], s[3:0], w[1:0]};
  endfunction

  // memory model with fixed latency and one-cycle acknowledge
  int          lat = 0;
  bit          hs_busy = 0;
  logic [21:0] hs_addr;
  logic        hs_we;
  always @(posedge clk) begin
    if (mem_ack) begin
      mem_ack <= 1'b0;
      lat     <= 0;
      hs_busy = 0;
    end else if (mem_req) begin
      if (hs_busy && (mem_addr != hs_addr || mem_we != hs_we)) hs_bad++;
      hs_busy = 1; hs_addr = mem_addr; hs_we = mem_we;
      if (lat == LAT) begin
        mem_ack <= 1'b1;
        if (mem_we) begin
          wbs++; last_wb = mem_addr; last_wb_line = mem_wdata;
          if (wb_n < 64) begin wb_a[wb_n] = mem_addr; wb_l[wb_n] = mem_wdata; wb_n++; end
        end else begin
          fills++; last_fill = mem_addr;
          mem_rdata <= line_of(mem_addr);
        end
      end else lat <= lat + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // one processor access, held until ready; returns data and wait cycles
  task automatic access(input bit we, input logic [23:0] a, input logic [15:0] wd,
                        output logic [15:0] rd, output int cyc);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd; cyc = 0;
    forever begin
      #1;
      if (cpu_ready && mem_req) overlap++;
      if (cpu_ready) break;
      @(negedge clk);
      cyc++;
      if (cyc > 200) break;
    end
    rd = cpu_rdata;
    @(posedge clk);
    #1;
    cpu_req = 1'b0; cpu_we = 1'b0;
    if (we && gw_n < 64) begin gw_a[gw_n] = a; gw_d[gw_n] = wd; gw_n++; end
  endtask

  task automatic t_reset();
    #1;
    chk(cpu_ready == 1'b0, "R10", "ready after reset", 64'(cpu_ready), 0);
    chk(mem_req == 1'b0, "R10", "mem_req after reset", 64'(mem_req), 0);
  endtask

  task automatic t_miss_then_hit();
    logic [15:0] rd; int c, f0, w0;
    f0 = fills; w0 = wbs;
    access(0, mk(1, 3, 2), 0, rd, c);
    chk(fills == f0 + 1 && wbs == w0, "R10", "first access misses with one fill", 64'(fills - f0), 1);
    chk(last_fill == mk(1, 3, 2) >> 2, "R4", "fill block address", 64'(last_fill), 64'(mk(1, 3, 2) >> 2));
    chk(rd == golden(mk(1, 3, 2)), "R4", "miss read data", 64'(rd), 64'(golden(mk(1, 3, 2))));
    chk(c > LAT, "R11", "ready held low during fill", 64'(c), LAT + 1);
    access(0, mk(1, 3, 0), 0, rd, c);
    chk(c == 0 && fills == f0 + 1, "R2", "hit same cycle without fill", 64'(c), 0);
    chk(rd == golden(mk(1, 3, 0)), "R1", "word offset 0 select", 64'(rd), 64'(golden(mk(1, 3, 0))));
    access(0, mk(1, 3, 3), 0, rd, c);
    chk(rd == golden(mk(1, 3, 3)), "R1", "word offset 3 select", 64'(rd), 64'(golden(mk(1, 3, 3))));
  endtask

  task automatic t_two_ways();
    logic [15:0] rd; int c, f0;
    access(0, mk(2, 3, 1), 0, rd, c);
    f0 = fills;
    access(0, mk(1, 3, 1), 0, rd, c);
    chk(c == 0 && fills == f0, "R3", "first block still resident", 64'(c), 0);
    access(0, mk(2, 3, 3), 0, rd, c);
    chk(c == 0 && fills == f0, "R3", "second block resident", 64'(c), 0);
    chk(rd == golden(mk(2, 3, 3)), "R3", "second block data", 64'(rd), 64'(golden(mk(2, 3, 3))));
  endtask

  task automatic t_lru();
    logic [15:0] rd; int c, f0, w0;
    access(0, mk(1, 3, 0), 0, rd, c);     // tag 2 becomes least recent
    w0 = wbs; f0 = fills;
    access(0, mk(5, 3, 0), 0, rd, c);     // evicts tag 2
    chk(fills == f0 + 1 && wbs == w0, "R7", "clean victim not written back", 64'(wbs - w0), 0);
    access(0, mk(1, 3, 2), 0, rd, c);
    chk(c == 0, "R5", "recent block kept", 64'(c), 0);
    f0 = fills;
    access(0, mk(2, 3, 0), 0, rd, c);
    chk(fills == f0 + 1, "R5", "LRU block was evicted", 64'(fills - f0), 1);
    access(0, mk(1, 3, 1), 0, rd, c);
    chk(c == 0, "R5", "tag 1 survives second eviction", 64'(c), 0);
    f0 = fills;
    access(0, mk(5, 3, 0), 0, rd, c);
    chk(fills == f0 + 1, "R5", "tag 5 evicted as LRU", 64'(fills - f0), 1);
  endtask

  task automatic t_write_hit_evict();
    logic [15:0] rd; int c, f0, w0;
    access(0, mk(7, 5, 0), 0, rd, c);
    f0 = fills; w0 = wbs;
    access(1, mk(7, 5, 1), 16'hBEEF, rd, c);
    chk(c == 0 && fills == f0 && wbs == w0, "R6", "write hit stays in cache", 64'(wbs - w0), 0);
    access(0, mk(7, 5, 1), 0, rd, c);
    chk(rd == 16'hBEEF, "R6", "write hit read back", 64'(rd), 64'hBEEF);
    access(0, mk(8, 5, 0), 0, rd, c);     // fills the empty way (R5)
    chk(wbs == w0, "R5", "empty way used before dirty way", 64'(wbs - w0), 0);
    access(0, mk(9, 5, 0), 0, rd, c);
    chk(wbs == w0 + 1, "R7", "dirty victim written back", 64'(wbs - w0), 1);
    chk(last_wb == mk(7, 5, 0) >> 2, "R7", "write-back address", 64'(last_wb), 64'(mk(7, 5, 0) >> 2));
    chk(last_wb_line[31:16] == 16'hBEEF, "R7", "write-back word 1", 64'(last_wb_line[31:16]), 64'hBEEF);
    chk(last_wb_line[15:0] == golden(mk(7, 5, 0)), "R7", "write-back word 0",
        64'(last_wb_line[15:0]), 64'(golden(mk(7, 5, 0))));
    access(0, mk(10, 5, 0), 0, rd, c);
    chk(wbs == w0 + 1, "R7", "clean victim skipped", 64'(wbs - w0), 1);
    access(0, mk(7, 5, 1), 0, rd, c);
    chk(rd == 16'hBEEF, "R7", "written-back data refetched", 64'(rd), 64'hBEEF);
  endtask

  task automatic t_write_miss();
    logic [15:0] rd; int c, f0, w0;
    f0 = fills; w0 = wbs;
    access(1, mk(11, 9, 2), 16'h1234, rd, c);
    chk(fills == f0 + 1 && wbs == w0 && c > 0, "R8", "write miss allocates", 64'(fills - f0), 1);
    access(0, mk(11, 9, 2), 0, rd, c);
    chk(c == 0 && rd == 16'h1234, "R8", "merged word", 64'(rd), 64'h1234);
    access(0, mk(11, 9, 0), 0, rd, c);
    chk(rd == golden(mk(11, 9, 0)), "R8", "untouched word keeps memory value",
        64'(rd), 64'(golden(mk(11, 9, 0))));
    access(0, mk(12, 9, 0), 0, rd, c);
    access(0, mk(13, 9, 0), 0, rd, c);
    chk(wbs == w0 + 1 && last_wb_line[47:32] == 16'h1234, "R8", "allocated line dirty",
        64'(last_wb_line[47:32]), 64'h1234);
  endtask

  initial begin
    #(8 * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_miss_then_hit();
    t_two_ways();
    t_lru();
    t_write_hit_evict();
    t_write_miss();
    chk(hs_bad == 0, "R9", "request held stable until ack", 64'(hs_bad), 0);
    chk(overlap == 0, "R11", "ready never with mem_req", 64'(overlap), 0);
    repeat (2) @(posedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule